// File: doc/BRIEF.md
# Host Port Pin GPIO Overlay

This block sits between the pads of a parallel host port and the host protocol logic, and adds a general-purpose I/O layer on top of them. The port has a 16-bit data bus made of two bytes, a pair of control-select inputs and an address strobe. Each of these four pin groups has one takeover bit. While a group's takeover bit is clear, its pads carry the host logic's output and output-enable, and the host logic sees the real pad levels. While the bit is set, each pad in the group follows its own direction and data bits. The host logic then sees a fixed substitute level on those pins, whatever the pad is doing.

Software reaches the block through a small single-cycle register port with per-bit write masks. There are three registers: takeover, direction and data. A data read returns, for each pin, the stored value for an output or the synchronized pad level for an input. A data write only lands on bits whose direction is output.

Top module: `pin_gpio_overlay`

## Requirements
- R1: While reset is asserted and right after it, the takeover, direction and data registers read 0, so every pin is a host pin and, if taken over, an input.
- R2: For a pin whose group takeover bit is 0, pad_out equals host_out, pad_oe equals host_oe, and host_in equals pad_in.
- R3: For a pin whose group takeover bit is 1, pad_out equals its data bit and pad_oe equals its direction bit (1 = drive, 0 = input).
- R4: For a taken-over pin, host_in is forced: 0 for every data-bus pin, 1 for both control-select pins and for the address strobe.
- R5: Takeover bit 0 covers pins 7:0 (low data byte), bit 1 covers pins 15:8 (high data byte), bit 2 covers pins 17:16 (control-select pair), and bit 3 covers pin 18 (address strobe).
- R6: Register address 2 is the data register. Reading it returns the last written data value in every bit whose direction bit is 1.
- R7: A write to the data register leaves unchanged every bit whose direction bit is 0.
- R8: Reading the data register returns, in every bit whose direction bit is 0, the pad level as it was two clock edges earlier, after a two-flop synchronizer.
- R9: Register address 0 is takeover (bits 3:0) and address 1 is direction (bits 18:0). A write changes only the bits whose reg_wmask bit is 1.
- R10: A takeover write changes the pad mux and the forced host input only after the clock edge that captures the write, and never before it.
- R11: Address 3 reads as 0, and a write to it changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 2 | Register select: 0 takeover, 1 direction, 2 data, 3 unused |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_wdata | input | 32 | Write data |
| reg_wmask | input | 32 | Per-bit write mask |
| reg_rdata | output | 32 | Combinational read data for reg_addr |
| pad_in | input | 19 | Pad input levels |
| pad_out | output | 19 | Pad output levels |
| pad_oe | output | 19 | Pad output enables |
| host_out | input | 19 | Output levels from host protocol logic |
| host_oe | input | 19 | Output enables from host protocol logic |
| host_in | output | 19 | Pin levels as seen by host protocol logic |

## Verification
The main function is tested with four takeover patterns, each naming a single group. Only one group's pins may change ownership at a time, and the forced level has to match that group's own constant. This separates the data bytes, which are forced to 0, from the control and strobe pins, which are forced to 1. The register side is tested with a mix of input and output bits in one register, so a read has to pick the stored value or the pad level bit by bit. A write to input bits is later exposed by switching those bits to output. A pad change is tracked across two edges to pin down the synchronizer delay. A takeover write is checked before and after its edge to show the one-cycle latency.

// File: rtl/pgo_pkg.sv
package pgo_pkg;
    localparam int NGRP     = 4;
    localparam int GRP_LO   = 0;
    localparam int GRP_HI   = 1;
    localparam int GRP_CTL  = 2;
    localparam int GRP_STB  = 3;

    typedef enum logic [1:0] {
        ADDR_TAKE = 2'd0,
        ADDR_DIR  = 2'd1,
        ADDR_DAT  = 2'd2,
        ADDR_NONE = 2'd3
    } reg_addr_e;
endpackage

// File: rtl/pgo_sync.sv
module pgo_sync #(
    parameter int W = 19
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = din;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dout = st_q.s2;
endmodule

// File: rtl/pgo_regs.sv
module pgo_regs
    import pgo_pkg::*;
#(
    parameter int NPIN  = 19,
    parameter int REG_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       addr,
    input  logic             wr,
    input  logic [REG_W-1:0] wdata,
    input  logic [REG_W-1:0] wmask,
    input  logic [NPIN-1:0]  sync_in,
    output logic [NGRP-1:0]  take_q,
    output logic [NPIN-1:0]  dir_q,
    output logic [NPIN-1:0]  dat_q,
    output logic [REG_W-1:0] rdata
);
    typedef struct packed {
        logic [NGRP-1:0] take;
        logic [NPIN-1:0] dir;
        logic [NPIN-1:0] dat;
    } regs_t;

    regs_t r_d, r_q;
    logic [NPIN-1:0] dat_wm;

    always_comb begin
        r_d    = r_q;
        dat_wm = wmask[NPIN-1:0] & r_q.dir;
        rdata  = '0;
        if (wr) begin
            unique case (reg_addr_e'(addr))
                ADDR_TAKE: r_d.take = (r_q.take & ~wmask[NGRP-1:0]) | (wdata[NGRP-1:0] & wmask[NGRP-1:0]);
                ADDR_DIR:  r_d.dir  = (r_q.dir & ~wmask[NPIN-1:0]) | (wdata[NPIN-1:0] & wmask[NPIN-1:0]);
                ADDR_DAT:  r_d.dat  = (r_q.dat & ~dat_wm) | (wdata[NPIN-1:0] & dat_wm);
                default:   r_d      = r_q;
            endcase
        end
        unique case (reg_addr_e'(addr))
            ADDR_TAKE: rdata[NGRP-1:0] = r_q.take;
            ADDR_DIR:  rdata[NPIN-1:0] = r_q.dir;
            ADDR_DAT:  rdata[NPIN-1:0] = (r_q.dat & r_q.dir) | (sync_in & ~r_q.dir);
            default:   rdata           = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign take_q = r_q.take;
    assign dir_q  = r_q.dir;
    assign dat_q  = r_q.dat;
endmodule

// File: rtl/pgo_pinmux.sv
module pgo_pinmux
    import pgo_pkg::*;
#(
    parameter int BYTE_W = 8,
    parameter int CTL_W  = 2,
    localparam int NPIN  = 2*BYTE_W + CTL_W + 1
) (
    input  logic [NGRP-1:0] take,
    input  logic [NPIN-1:0] dir,
    input  logic [NPIN-1:0] dat,
    input  logic [NPIN-1:0] pad_in,
    input  logic [NPIN-1:0] host_out,
    input  logic [NPIN-1:0] host_oe,
    output logic [NPIN-1:0] pad_out,
    output logic [NPIN-1:0] pad_oe,
    output logic [NPIN-1:0] host_in
);
    for (genvar i = 0; i < NPIN; i++) begin : g_pin
        localparam int   GRP   = (i < BYTE_W)           ? GRP_LO  :
                                 (i < 2*BYTE_W)         ? GRP_HI  :
                                 (i < 2*BYTE_W + CTL_W) ? GRP_CTL : GRP_STB;
        localparam logic FORCE = (GRP == GRP_CTL) || (GRP == GRP_STB);

        assign pad_out[i] = take[GRP] ? dat[i]  : host_out[i];
        assign pad_oe[i]  = take[GRP] ? dir[i]  : host_oe[i];
        assign host_in[i] = take[GRP] ? FORCE   : pad_in[i];
    end
endmodule

// File: rtl/pin_gpio_overlay.sv
module pin_gpio_overlay
    import pgo_pkg::*;
#(
    parameter int BYTE_W = 8,
    parameter int CTL_W  = 2,
    parameter int REG_W  = 32,
    localparam int NPIN  = 2*BYTE_W + CTL_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       reg_addr,
    input  logic             reg_wr,
    input  logic [REG_W-1:0] reg_wdata,
    input  logic [REG_W-1:0] reg_wmask,
    output logic [REG_W-1:0] reg_rdata,
    input  logic [NPIN-1:0]  pad_in,
    output logic [NPIN-1:0]  pad_out,
    output logic [NPIN-1:0]  pad_oe,
    input  logic [NPIN-1:0]  host_out,
    input  logic [NPIN-1:0]  host_oe,
    output logic [NPIN-1:0]  host_in
);
    logic [NGRP-1:0] take_q;
    logic [NPIN-1:0] dir_q;
    logic [NPIN-1:0] dat_q;
    logic [NPIN-1:0] pin_sync;

    pgo_sync #(.W(NPIN)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (pad_in),
        .dout  (pin_sync)
    );

    pgo_regs #(.NPIN(NPIN), .REG_W(REG_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr    (reg_addr),
        .wr      (reg_wr),
        .wdata   (reg_wdata),
        .wmask   (reg_wmask),
        .sync_in (pin_sync),
        .take_q  (take_q),
        .dir_q   (dir_q),
        .dat_q   (dat_q),
        .rdata   (reg_rdata)
    );

    pgo_pinmux #(.BYTE_W(BYTE_W), .CTL_W(CTL_W)) u_mux (
        .take     (take_q),
        .dir      (dir_q),
        .dat      (dat_q),
        .pad_in   (pad_in),
        .host_out (host_out),
        .host_oe  (host_oe),
        .pad_out  (pad_out),
        .pad_oe   (pad_oe),
        .host_in  (host_in)
    );
endmodule

// File: rtl/pin_gpio_overlay_chk.sv
module pin_gpio_overlay_chk
    import pgo_pkg::*;
#(
    parameter int BYTE_W = 8,
    parameter int CTL_W  = 2,
    parameter int REG_W  = 32,
    localparam int NPIN  = 2*BYTE_W + CTL_W + 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic [1:0]       reg_addr,
    input logic             reg_wr,
    input logic [REG_W-1:0] reg_wmask,
    input logic [NPIN-1:0]  pad_in,
    input logic [NPIN-1:0]  pad_out,
    input logic [NPIN-1:0]  pad_oe,
    input logic [NPIN-1:0]  host_out,
    input logic [NPIN-1:0]  host_oe,
    input logic [NPIN-1:0]  host_in,
    input logic [NGRP-1:0]  take_q,
    input logic [NPIN-1:0]  dir_q,
    input logic [NPIN-1:0]  dat_q
);
    always @(negedge clk) begin
        if (!rst_n) begin
            // R1
            reset_clear_chk: assert (take_q == '0 && dir_q == '0 && dat_q == '0);
        end
    end

    // R2
    host_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take_q == '0) |-> (pad_out == host_out && pad_oe == host_oe && host_in == pad_in));

    // R4
    strobe_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take_q[GRP_STB] |-> host_in[NPIN-1]);

    // R7
    input_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == ADDR_DAT) |=>
        ((dat_q & ~$past(dir_q)) == ($past(dat_q) & ~$past(dir_q))));

    // R9
    dir_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == ADDR_DIR) |=>
        ((dir_q & ~$past(reg_wmask[NPIN-1:0])) == ($past(dir_q) & ~$past(reg_wmask[NPIN-1:0]))));

    // R10
    take_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr && reg_addr == ADDR_TAKE) |=> $stable(take_q));
endmodule

bind pin_gpio_overlay pin_gpio_overlay_chk #(
    .BYTE_W (BYTE_W),
    .CTL_W  (CTL_W),
    .REG_W  (REG_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_addr  (reg_addr),
    .reg_wr    (reg_wr),
    .reg_wmask (reg_wmask),
    .pad_in    (pad_in),
    .pad_out   (pad_out),
    .pad_oe    (pad_oe),
    .host_out  (host_out),
    .host_oe   (host_oe),
    .host_in   (host_in),
    .take_q    (take_q),
    .dir_q     (dir_q),
    .dat_q     (dat_q)
);

// File: tb/pin_gpio_overlay_bench.sv
`timescale 1ns/100ps
module pin_gpio_overlay_bench;
    localparam int NP = 19;
    localparam logic [1:0] A_TAKE = 2'd0, A_DIR = 2'd1, A_DAT = 2'd2, A_NONE = 2'd3;
    localparam int S_RD = 0, S_POUT = 1, S_POE = 2, S_HIN = 3;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [1:0]    reg_addr;
    logic          reg_wr;
    logic [31:0]   reg_wdata, reg_wmask, reg_rdata;
    logic [NP-1:0] pad_in, pad_out, pad_oe, host_out, host_oe, host_in;

    always #2.5 clk = ~clk;

    pin_gpio_overlay u_pin_gpio_overlay (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_wmask(reg_wmask), .reg_rdata(reg_rdata),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
        .host_out(host_out), .host_oe(host_oe), .host_in(host_in)
    );

    typedef struct {
        int          sel;
        logic [31:0] exp;
        string       req;
    } item_t;

    item_t q[$];
    event  push_ev;
    int    n_run  = 0;
    int    n_fail = 0;
    bit    done   = 0;

    initial begin
        forever begin
            @(push_ev);
            while (q.size() > 0) begin
                item_t it;
                logic [31:0] got;
                it = q.pop_front();
                case (it.sel)
                    S_RD:    got = reg_rdata;
                    S_POUT:  got = 32'(pad_out);
                    S_POE:   got = 32'(pad_oe);
                    default: got = 32'(host_in);
                endcase
                n_run++;
                if (got !== it.exp) begin
                    n_fail++;
                    $display("FAIL %s: got %h expected %h", it.req, got, it.exp);
                end
            end
        end
    end

    task automatic push(int sel, logic [31:0] exp, string req);
        item_t it;
        it.sel = sel; it.exp = exp; it.req = req;
        q.push_back(it);
        -> push_ev;
        #0.5;
    endtask

    task automatic wr(logic [1:0] a, logic [31:0] d, logic [31:0] m);
        @(negedge clk);
        reg_addr = a; reg_wr = 1'b1; reg_wdata = d; reg_wmask = m;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic chk(int sel, logic [1:0] a, logic [31:0] exp, string req);
        @(negedge clk);
        reg_addr = a;
        #0.5;
        push(sel, exp, req);
    endtask

    initial begin
        #200000ns;
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: got hang expected finish");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; reg_addr = A_TAKE; reg_wr = 1'b0;
        reg_wdata = '0; reg_wmask = '0;
        pad_in = 19'h2A5C3; host_out = 19'h5A55A; host_oe = 19'h7F0F0;
        repeat (3) @(negedge clk);
        chk(S_RD,  A_TAKE, 32'h0, "R1 takeover after reset");
        chk(S_RD,  A_DIR,  32'h0, "R1 direction after reset");
        chk(S_POE, A_TAKE, 32'h7F0F0, "R2 pad_oe in reset");
        @(negedge clk); rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(S_HIN,  A_TAKE, 32'h2A5C3, "R2 host_in passthrough");
        chk(S_POUT, A_TAKE, 32'h5A55A, "R2 pad_out passthrough");
        chk(S_RD,   A_DAT,  32'h2A5C3, "R8 input read");

        wr(A_DAT, 32'hFFFFFFFF, 32'hFFFFFFFF);
        wr(A_DIR, 32'hFFFFFFFF, 32'h000000FF);
        chk(S_RD, A_DIR, 32'h000FF, "R9 direction masked write");
        chk(S_RD, A_DAT, 32'h2A500, "R7 discarded write to inputs");
        wr(A_DAT, 32'h000000A5, 32'hFFFFFFFF);
        chk(S_RD, A_DAT, 32'h2A5A5, "R6 output readback");

        // R8: pad change visible after two edges
        @(negedge clk);
        reg_addr = A_DAT; pad_in = 19'h15A3C;
        #0.5; push(S_RD, 32'h2A5A5, "R8 sync edge0");
        @(negedge clk); #0.5; push(S_RD, 32'h2A5A5, "R8 sync edge1");
        @(negedge clk); #0.5; push(S_RD, 32'h15AA5, "R8 sync edge2");

        // R10: takeover of low byte, before and after its edge
        @(negedge clk);
        reg_addr = A_TAKE; reg_wr = 1'b1; reg_wdata = 32'h1; reg_wmask = 32'hF;
        #0.5; push(S_POE, 32'h7F0F0, "R10 before edge");
        @(negedge clk); reg_wr = 1'b0;
        #0.5; push(S_POE, 32'h7F0FF, "R10 after edge");
        chk(S_POUT, A_TAKE, 32'h5A5A5, "R3 pad_out from data bits");
        chk(S_HIN,  A_TAKE, 32'h15A00, "R4 low byte forced 0");

        wr(A_TAKE, 32'h8, 32'hF);
        chk(S_HIN, A_TAKE, 32'h55A3C, "R5 strobe group forced 1");
        chk(S_POE, A_TAKE, 32'h3F0F0, "R5 strobe group pad_oe");
        wr(A_TAKE, 32'h4, 32'hF);
        chk(S_HIN, A_TAKE, 32'h35A3C, "R4 control pair forced 1");
        wr(A_TAKE, 32'h2, 32'hF);
        chk(S_HIN, A_TAKE, 32'h1003C, "R5 high byte forced 0");
        chk(S_POE, A_TAKE, 32'h700F0, "R3 high byte pad_oe from direction");

        wr(A_TAKE, 32'hF, 32'h5);
        chk(S_RD, A_TAKE, 32'h7, "R9 takeover masked write");

        wr(A_NONE, 32'hFFFFFFFF, 32'hFFFFFFFF);
        chk(S_RD, A_NONE, 32'h0,     "R11 unused address reads 0");
        chk(S_RD, A_TAKE, 32'h7,     "R11 takeover unchanged");
        chk(S_RD, A_DIR,  32'h000FF, "R11 direction unchanged");

        repeat (2) @(negedge clk);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule